// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Late Arrival and Tail-Chaining

This block sits beside a simple processor model and decides which interrupt handler runs. It watches N request lines. Each source has a priority that software can change at any time. The block enters the best pending source through a timed context-save phase and leaves a handler through a timed context-restore phase. The save and restore are modelled only as timed phases; no memory is written. A small stack of interrupted handlers lets nested handlers resume at the correct running priority.

Two shortcuts shorten back-to-back servicing. A more urgent request that arrives while the context is still being saved takes over the vector, and the save is not restarted. When a handler returns and another qualifying request is waiting, the block goes straight to that handler through a short vector-fetch phase. It skips the restore and the second save.

Priority value 0 is the most urgent. The running priority reads 2^PW when no handler is active. With the default timing, a plain exit followed by a new entry costs 12 cycles, and a chained transition costs 6 cycles.

Top module: `vic_chain`

## Requirements
- R1: A source becomes pending on a rising edge of its request line; holding the line high does not make it pending again once it is taken. Pulsing bit i of `pend_set` sets pending bit i, and pulsing bit i of `pend_clr` clears it. When both happen in the same cycle, the set wins.
- R2: Among pending sources, the one with the numerically lowest priority is selected. On equal priorities the lowest source index wins. A priority write (`prio_we`, `prio_sel`, `prio_val`) takes effect on the next arbitration.
- R3: From idle, a pending source causes `stacking` to stay high for exactly STACK_CYC (default 6) cycles. Then `in_handler` rises, with `vec_idx` equal to the selected source and `run_prio` equal to its priority, and that source's pending bit is cleared.
- R4: A pending source whose priority is strictly more urgent than the one being entered replaces the vector if it appears during stacking. Stacking still lasts STACK_CYC cycles in total, and the displaced source stays pending.
- R5: While a handler runs, only a pending source with priority strictly more urgent than `run_prio` pre-empts it. A pre-emption starts stacking and raises `nest_lvl` by one. Sources of equal or less urgent priority wait.
- R6: When `hdl_done` is pulsed and no qualifying request is waiting, `unstacking` is high for UNSTACK_CYC (default 6) cycles. The block then resumes the interrupted handler, with its `vec_idx` and `run_prio` restored and `nest_lvl` lowered by one. If no handler was interrupted, it returns to idle with `run_prio` = 2^PW and `nest_lvl` = 0.
- R7: A request qualifies at `hdl_done` when its priority is strictly more urgent than the level being returned to. In that case `chaining` is high for CHAIN_CYC (default 6) cycles, with no stacking or unstacking, and then `in_handler` rises on the new vector with `nest_lvl` unchanged.
- R8: At most one of `stacking`, `unstacking`, `chaining` and `in_handler` is high in any cycle.
- R9: After reset, no source is pending, all four status outputs are low, `run_prio` = 2^PW and `nest_lvl` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | N | Request lines, rising edge makes a source pending |
| prio_we | input | 1 | Priority write strobe |
| prio_sel | input | log2(N) | Source whose priority is written |
| prio_val | input | PW | New priority value, 0 most urgent |
| pend_set | input | N | Software set of pending bits |
| pend_clr | input | N | Software clear of pending bits |
| hdl_done | input | 1 | Running handler returns (one-cycle pulse) |
| pending | output | N | Pending bits |
| vec_idx | output | log2(N) | Vector of the running or entered handler |
| in_handler | output | 1 | A handler is running |
| stacking | output | 1 | Context save phase |
| unstacking | output | 1 | Context restore phase |
| chaining | output | 1 | Direct vector fetch between handlers |
| run_prio | output | PW+1 | Running priority, 2^PW when idle |
| nest_lvl | output | log2(2^PW+1) | Number of interrupted handlers held |

## Verification
A wrong selection register shows up as a wrong `vec_idx` on the cycle `in_handler` rises. The pending bits also give it away, because the displaced or waiting source stays set when it should have cleared, or clears when it should have stayed set. A corrupted entry in the stack of interrupted handlers is visible only when a return finishes its restore phase: the resumed `vec_idx` or `run_prio` is wrong, or a waiting request chains or fails to chain. The bench therefore counts the cycles of each phase and reads the vector and level after every transition. The sweeps vary priorities and pending masks so that errors in tie-breaking and in the strict comparisons appear within one entry.

// File: rtl/ic_pkg.sv
package ic_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_STACK   = 3'd1,
    ST_ACT     = 3'd2,
    ST_UNSTACK = 3'd3,
    ST_CHAIN   = 3'd4
  } ic_state_e;
endpackage

// File: rtl/ic_pend.sv
module ic_pend #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_req,
  input  logic [N-1:0]  pend_set,
  input  logic [N-1:0]  pend_clr,
  input  logic          take_vld,
  input  logic [IW-1:0] take_idx,
  output logic [N-1:0]  pend_q
);
  logic [N-1:0] irq_d;
  logic [N-1:0] rise;
  logic [N-1:0] take_mask;

  always_comb begin
    rise = irq_req & ~irq_d;
    for (int i = 0; i < N; i++) begin
      take_mask[i] = take_vld && (take_idx == IW'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_d  <= '0;
      pend_q <= '0;
    end else begin
      irq_d  <= irq_req;
      // a new set on the same edge wins over any clear
      pend_q <= (pend_q & ~(pend_clr | take_mask)) | rise | pend_set;
    end
  end
endmodule

// File: rtl/ic_arb.sv
module ic_arb #(
  parameter int N  = 8,
  parameter int PW = 3,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]    pend,
  input  logic [N*PW-1:0] prio_flat,
  output logic            best_vld,
  output logic [IW-1:0]   best_idx,
  output logic [PW-1:0]   best_prio
);
  always_comb begin
    best_vld  = 1'b0;
    best_idx  = '0;
    best_prio = '0;
    for (int i = 0; i < N; i++) begin
      // strict compare keeps the lowest index on a tie
      if (pend[i] && (!best_vld || (prio_flat[i*PW +: PW] < best_prio))) begin
        best_vld  = 1'b1;
        best_idx  = IW'(i);
        best_prio = prio_flat[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/ic_stack.sv
module ic_stack #(
  parameter int IW    = 3,
  parameter int PW    = 3,
  parameter int DEPTH = 8,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [IW-1:0] wr_idx,
  input  logic [PW-1:0] wr_prio,
  output logic [IW-1:0] top_idx,
  output logic [PW-1:0] top_prio,
  output logic [DW-1:0] depth
);
  logic [IW+PW-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_addr;
  logic [AW-1:0]    rd_addr;

  assign wr_addr = AW'(depth);
  assign rd_addr = AW'(depth - DW'(1));

  always_ff @(posedge clk) begin
    if (push) mem[wr_addr] <= {wr_idx, wr_prio};
  end

  assign {top_idx, top_prio} = mem[rd_addr];

  always_ff @(posedge clk) begin
    if (rst) depth <= '0;
    else if (push && !pop) depth <= depth + DW'(1);
    else if (pop && !push) depth <= depth - DW'(1);
  end
endmodule

// File: rtl/vic_chain.sv
module vic_chain #(
  parameter int N           = 8,
  parameter int PW          = 3,
  parameter int STACK_CYC   = 6,
  parameter int UNSTACK_CYC = 6,
  parameter int CHAIN_CYC   = 6,
  localparam int IW    = $clog2(N),
  localparam int DEPTH = 2 ** PW,
  localparam int DW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  irq_req,
  input  logic          prio_we,
  input  logic [IW-1:0] prio_sel,
  input  logic [PW-1:0] prio_val,
  input  logic [N-1:0]  pend_set,
  input  logic [N-1:0]  pend_clr,
  input  logic          hdl_done,
  output logic [N-1:0]  pending,
  output logic [IW-1:0] vec_idx,
  output logic          in_handler,
  output logic          stacking,
  output logic          unstacking,
  output logic          chaining,
  output logic [PW:0]   run_prio,
  output logic [DW-1:0] nest_lvl
);
  import ic_pkg::*;

  localparam int MAXC0 = (STACK_CYC > UNSTACK_CYC) ? STACK_CYC : UNSTACK_CYC;
  localparam int MAXC  = (MAXC0 > CHAIN_CYC) ? MAXC0 : CHAIN_CYC;
  localparam int CW    = $clog2(MAXC + 1);
  localparam logic [CW-1:0] ST_LAST = CW'(STACK_CYC - 1);
  localparam logic [CW-1:0] UN_LAST = CW'(UNSTACK_CYC - 1);
  localparam logic [CW-1:0] CH_LAST = CW'(CHAIN_CYC - 1);
  localparam logic [PW:0]   IDLE_P  = (PW+1)'(DEPTH);

  ic_state_e     st;
  logic [CW-1:0] cnt;
  logic [IW-1:0] sel_idx_q;
  logic [PW-1:0] sel_prio_q;
  logic [IW-1:0] cur_idx_q;
  logic [PW:0]   cur_prio_q;
  logic [PW-1:0] prio_q [N];
  logic [N*PW-1:0] prio_flat;

  logic          best_vld;
  logic [IW-1:0] best_idx;
  logic [PW-1:0] best_prio;
  logic [IW-1:0] top_idx;
  logic [PW-1:0] top_prio;
  logic [DW-1:0] depth;

  logic          sub;
  logic [IW-1:0] nsel_idx;
  logic [PW-1:0] nsel_prio;
  logic [PW:0]   restore_thr;
  logic          chain_ok;
  logic          preempt;
  logic          commit;
  logic          push;
  logic          pop;

  // software-visible priority registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) prio_q[i] <= '0;
    end else if (prio_we) begin
      prio_q[prio_sel] <= prio_val;
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) prio_flat[i*PW +: PW] = prio_q[i];
  end

  ic_pend #(.N(N)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .irq_req  (irq_req),
    .pend_set (pend_set),
    .pend_clr (pend_clr),
    .take_vld (commit),
    .take_idx (nsel_idx),
    .pend_q   (pending)
  );

  ic_arb #(.N(N), .PW(PW)) u_arb (
    .pend      (pending),
    .prio_flat (prio_flat),
    .best_vld  (best_vld),
    .best_idx  (best_idx),
    .best_prio (best_prio)
  );

  ic_stack #(.IW(IW), .PW(PW), .DEPTH(DEPTH)) u_stack (
    .clk      (clk),
    .rst      (rst),
    .push     (push),
    .pop      (pop),
    .wr_idx   (cur_idx_q),
    .wr_prio  (cur_prio_q[PW-1:0]),
    .top_idx  (top_idx),
    .top_prio (top_prio),
    .depth    (depth)
  );

  always_comb begin
    // late arrival: a strictly more urgent source replaces the selection
    sub         = best_vld && (best_prio < sel_prio_q);
    nsel_idx    = sub ? best_idx  : sel_idx_q;
    nsel_prio   = sub ? best_prio : sel_prio_q;
    restore_thr = (depth != '0) ? {1'b0, top_prio} : IDLE_P;
    chain_ok    = best_vld && ({1'b0, best_prio} < restore_thr);
    preempt     = best_vld && ({1'b0, best_prio} < cur_prio_q);
    commit      = ((st == ST_STACK) && (cnt == ST_LAST)) ||
                  ((st == ST_CHAIN) && (cnt == CH_LAST));
    push        = (st == ST_ACT) && !hdl_done && preempt;
    pop         = (st == ST_UNSTACK) && (cnt == UN_LAST) && (depth != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      sel_idx_q  <= '0;
      sel_prio_q <= '0;
      cur_idx_q  <= '0;
      cur_prio_q <= IDLE_P;
    end else begin
      case (st)
        ST_IDLE: begin
          if (best_vld) begin
            st         <= ST_STACK;
            cnt        <= '0;
            sel_idx_q  <= best_idx;
            sel_prio_q <= best_prio;
          end
        end
        ST_ACT: begin
          if (hdl_done) begin
            cnt <= '0;
            if (chain_ok) begin
              st         <= ST_CHAIN;
              sel_idx_q  <= best_idx;
              sel_prio_q <= best_prio;
            end else begin
              st <= ST_UNSTACK;
            end
          end else if (preempt) begin
            st         <= ST_STACK;
            cnt        <= '0;
            sel_idx_q  <= best_idx;
            sel_prio_q <= best_prio;
          end
        end
        ST_STACK, ST_CHAIN: begin
          sel_idx_q  <= nsel_idx;
          sel_prio_q <= nsel_prio;
          if (commit) begin
            st         <= ST_ACT;
            cur_idx_q  <= nsel_idx;
            cur_prio_q <= {1'b0, nsel_prio};
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        ST_UNSTACK: begin
          if (cnt == UN_LAST) begin
            if (depth != '0) begin
              st         <= ST_ACT;
              cur_idx_q  <= top_idx;
              cur_prio_q <= {1'b0, top_prio};
            end else begin
              st         <= ST_IDLE;
              cur_idx_q  <= '0;
              cur_prio_q <= IDLE_P;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign vec_idx    = cur_idx_q;
  assign run_prio   = cur_prio_q;
  assign nest_lvl   = depth;
  assign in_handler = (st == ST_ACT);
  assign stacking   = (st == ST_STACK);
  assign unstacking = (st == ST_UNSTACK);
  assign chaining   = (st == ST_CHAIN);
endmodule

// File: rtl/vic_chain_chk.sv
module vic_chain_chk #(
  parameter int N         = 8,
  parameter int PW        = 3,
  parameter int STACK_CYC = 6,
  localparam int IW = $clog2(N),
  localparam int DW = $clog2(2 ** PW + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [IW-1:0] vec_idx,
  input logic          in_handler,
  input logic          stacking,
  input logic          unstacking,
  input logic          chaining,
  input logic [PW:0]   run_prio,
  input logic [DW-1:0] nest_lvl
);
  localparam logic [PW:0] IDLE_P = (PW+1)'(2 ** PW);
  logic [15:0] stk_run;

  always_ff @(posedge clk) begin
    if (rst) stk_run <= '0;
    else if (stacking) stk_run <= stk_run + 16'd1;
    else stk_run <= '0;
  end

  // R8
  excl_status_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({in_handler, stacking, unstacking, chaining}));

  // R3
  stack_len_chk: assert property (@(posedge clk) disable iff (rst)
    stk_run <= 16'(STACK_CYC));

  // R3
  stack_to_run_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stacking) |-> in_handler && (run_prio < IDLE_P));

  // R5
  steady_run_chk: assert property (@(posedge clk) disable iff (rst)
    (in_handler && $past(in_handler)) |-> ($stable(vec_idx) && $stable(run_prio)));

  // R5
  nest_push_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(stacking) && $past(in_handler)) |-> (nest_lvl == $past(nest_lvl) + DW'(1)));

  // R7
  chain_nest_chk: assert property (@(posedge clk) disable iff (rst)
    chaining |=> $stable(nest_lvl));

  // R9
  idle_level_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_handler || stacking || unstacking || chaining) |-> (run_prio == IDLE_P && nest_lvl == '0));
endmodule

bind vic_chain vic_chain_chk #(.N(N), .PW(PW), .STACK_CYC(STACK_CYC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .vec_idx    (vec_idx),
  .in_handler (in_handler),
  .stacking   (stacking),
  .unstacking (unstacking),
  .chaining   (chaining),
  .run_prio   (run_prio),
  .nest_lvl   (nest_lvl)
);

// File: tb/sim_vic_chain.sv
`timescale 1ns/1ps
module sim_vic_chain;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int PW = 3;
  localparam int IW = 3;
  localparam int DW = 4;
  localparam int PHASE = 6;
  localparam int IDLE_P = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic [N-1:0]  irq_req;
  logic          prio_we;
  logic [IW-1:0] prio_sel;
  logic [PW-1:0] prio_val;
  logic [N-1:0]  pend_set;
  logic [N-1:0]  pend_clr;
  logic          hdl_done;
  logic [N-1:0]  pending;
  logic [IW-1:0] vec_idx;
  logic          in_handler, stacking, unstacking, chaining;
  logic [PW:0]   run_prio;
  logic [DW-1:0] nest_lvl;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int n_stk, n_uns, n_chn;
  int pr [N];
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vic_chain u0 (
    .clk(clk), .rst(rst), .irq_req(irq_req), .prio_we(prio_we),
    .prio_sel(prio_sel), .prio_val(prio_val), .pend_set(pend_set),
    .pend_clr(pend_clr), .hdl_done(hdl_done), .pending(pending),
    .vec_idx(vec_idx), .in_handler(in_handler), .stacking(stacking),
    .unstacking(unstacking), .chaining(chaining), .run_prio(run_prio),
    .nest_lvl(nest_lvl)
  );

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    cycles++;
    n_stk += int'(stacking);
    n_uns += int'(unstacking);
    n_chn += int'(chaining);
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  endtask

  task automatic clr_cnt();
    n_stk = 0; n_uns = 0; n_chn = 0;
  endtask

  task automatic setp(input int i, input int v);
    prio_we = 1'b1; prio_sel = IW'(i); prio_val = PW'(v); pr[i] = v;
    cyc();
    prio_we = 1'b0;
  endtask

  task automatic wait_run();
    int k;
    k = 0;
    while (in_handler && k < 200) begin cyc(); k++; end
    while (!in_handler && k < 200) begin cyc(); k++; end
    if (k >= 200) chk(1'b0, "wait_run timeout", k, 200);
  endtask

  task automatic wait_idle();
    int k;
    k = 0;
    while ((in_handler || stacking || unstacking || chaining) && k < 200) begin cyc(); k++; end
    if (k >= 200) chk(1'b0, "wait_idle timeout", k, 200);
  endtask

  task automatic done_pulse();
    hdl_done = 1'b1;
    cyc();
    hdl_done = 1'b0;
  endtask

  initial begin
    rst = 1'b1; irq_req = '0; prio_we = 0; prio_sel = '0; prio_val = '0;
    pend_set = '0; pend_clr = '0; hdl_done = 0;
    for (int i = 0; i < N; i++) pr[i] = 0;
    clr_cnt();
    repeat (3) cyc();
    rst = 1'b0;
    cyc();
    // R9 reset state
    chk(pending == '0, "R9 pending", int'(pending), 0);
    chk({in_handler, stacking, unstacking, chaining} == 4'b0, "R9 status",
        int'({in_handler, stacking, unstacking, chaining}), 0);
    chk(run_prio == IDLE_P, "R9 run_prio", int'(run_prio), IDLE_P);
    chk(nest_lvl == 0, "R9 nest_lvl", int'(nest_lvl), 0);

    // R1 edge detection with a held level
    setp(3, 4);
    irq_req[3] = 1'b1;
    cyc();
    chk(pending[3] == 1'b1, "R1 edge sets pending", int'(pending[3]), 1);
    clr_cnt();
    wait_run();
    chk(vec_idx == 3, "R3 vector", int'(vec_idx), 3);
    chk(n_stk == PHASE, "R3 stacking length", n_stk, PHASE);
    chk(pending[3] == 1'b0, "R1 held level not re-pended", int'(pending[3]), 0);
    done_pulse();
    wait_idle();
    repeat (10) cyc();
    chk(in_handler == 1'b0, "R1 no re-entry while held", int'(in_handler), 0);
    irq_req[3] = 1'b0;
    cyc();

    // R1 set wins over clear in the same cycle (no arbitration side effect checked)
    pend_set = 8'h01; pend_clr = 8'h01;
    cyc();
    pend_set = '0; pend_clr = '0;
    chk(pending[0] == 1'b1, "R1 set wins over clear", int'(pending[0]), 1);
    wait_run();
    done_pulse();
    wait_idle();

    // R2 R3 R6 sweep of priorities and masks
    for (int t = 0; t < 17; t++) begin
      int mask, ei, ep;
      for (int i = 0; i < N; i++) setp(i, (t == 16) ? 3 : ((i * 5 + t * 3) % 8));
      mask = (t == 16) ? 8'b0110_0100 : (((t * 37 + 11) % 255) + 1);
      ei = -1; ep = 99;
      for (int i = 0; i < N; i++) if (mask[i] && pr[i] < ep) begin ei = i; ep = pr[i]; end
      pend_set = N'(mask);
      cyc();
      pend_set = '0;
      clr_cnt();
      wait_run();
      chk(vec_idx == IW'(ei), "R2 winner", int'(vec_idx), ei);
      chk(run_prio == (PW+1)'(ep), "R3 run_prio", int'(run_prio), ep);
      chk(n_stk == PHASE, "R3 stacking length", n_stk, PHASE);
      pend_clr = '1;
      cyc();
      pend_clr = '0;
      chk(pending == '0, "R1 software clear", int'(pending), 0);
      clr_cnt();
      done_pulse();
      wait_idle();
      chk(n_uns == PHASE, "R6 unstacking length", n_uns, PHASE);
      chk(run_prio == IDLE_P && nest_lvl == 0, "R6 back to idle", int'(run_prio), IDLE_P);
    end

    // R4 late arrival, then R7 tail chain into the displaced source
    setp(5, 4); setp(2, 1);
    clr_cnt();
    pend_set = 8'h20;
    cyc();
    pend_set = '0;
    cyc(); cyc();
    chk(stacking == 1'b1, "R4 in stacking", int'(stacking), 1);
    pend_set = 8'h04;
    cyc();
    pend_set = '0;
    wait_run();
    chk(vec_idx == 2, "R4 substituted vector", int'(vec_idx), 2);
    chk(n_stk == PHASE, "R4 stacking not restarted", n_stk, PHASE);
    chk(pending[5] == 1'b1, "R4 displaced stays pending", int'(pending[5]), 1);
    clr_cnt();
    done_pulse();
    wait_run();
    chk(vec_idx == 5, "R7 chained vector", int'(vec_idx), 5);
    chk(n_chn == PHASE, "R7 chain length", n_chn, PHASE);
    chk(n_uns == 0 && n_stk == 0, "R7 no restore or save", n_uns + n_stk, 0);
    chk(nest_lvl == 0, "R7 nest unchanged", int'(nest_lvl), 0);
    done_pulse();
    wait_idle();

    // R5 pre-emption rules, R6 resume, R7 chain at the outer return
    setp(1, 5); setp(4, 5); setp(6, 2);
    pend_set = 8'h02;
    cyc();
    pend_set = '0;
    wait_run();
    clr_cnt();
    pend_set = 8'h10;
    cyc();
    pend_set = '0;
    repeat (10) cyc();
    chk(in_handler == 1'b1 && vec_idx == 1, "R5 equal priority waits", int'(vec_idx), 1);
    chk(n_stk == 0, "R5 no stacking on equal", n_stk, 0);
    pend_set = 8'h40;
    cyc();
    pend_set = '0;
    clr_cnt();
    wait_run();
    chk(vec_idx == 6, "R5 pre-empting vector", int'(vec_idx), 6);
    chk(nest_lvl == 1, "R5 nest level", int'(nest_lvl), 1);
    chk(run_prio == 2, "R5 run_prio", int'(run_prio), 2);
    clr_cnt();
    done_pulse();
    wait_run();
    chk(vec_idx == 1 && run_prio == 5, "R6 resumed handler", int'(vec_idx), 1);
    chk(nest_lvl == 0, "R6 nest lowered", int'(nest_lvl), 0);
    chk(n_uns == PHASE && n_chn == 0, "R6 restore used", n_uns, PHASE);
    clr_cnt();
    done_pulse();
    wait_run();
    chk(vec_idx == 4, "R7 chain to waiting source", int'(vec_idx), 4);
    chk(n_chn == PHASE && n_uns == 0, "R7 chain only", n_chn, PHASE);
    done_pulse();
    wait_idle();
    chk(run_prio == IDLE_P && nest_lvl == 0, "R6 final idle", int'(run_prio), IDLE_P);

    finish_run();
  end
endmodule